// File: doc/BRIEF.md
# Dual-width ALU with condition evaluation

This is the integer execution stage of a small 16-bit RISC core whose registers hold 24 bits. Each valid issue brings two 24-bit operands, an operation code, a width select, a carry qualifier, a branch-condition select and the current condition flags. One clock later the stage returns four things:

- the 24-bit result;
- a register write strobe;
- the next value of the four condition flags;
- the verdict of the selected branch condition, taken on the flags that came in with the issue.

Add, subtract and compare come in a 16-bit form and a full 24-bit form. The carry-chained forms (add with carry, subtract with borrow, compare with borrow) are always 16 bits wide. Logical operations, shifts and the byte swap also work on the low 16 bits and zero-fill the top byte. The conversions produce full 24-bit values.

Any arithmetic, compare or logical operation can be qualified so that it runs only when carry is set, or only when carry is clear. When the qualifier fails, the operation leaves no trace: nothing is written and the flags pass through unchanged. Decode, register file and memory sit outside this block.

Top module: `dual_width_alu`

## Requirements
- R1: While `rstN` is low, and after reset until the first issue, `outValid`, `outWrite`, `outTaken`, `outResult` and `outFlags` are all zero.
- R2: An issue sampled with `inValid` high at a rising edge shows its outputs after that same edge, one cycle of latency, and back-to-back issues are accepted. A cycle with `inValid` low gives `outValid` = 0 and `outWrite` = 0 after the next edge.
- R3: Flags use bit 0 = N, bit 1 = Z, bit 2 = V and bit 3 = C. For the 16-bit opcodes, only bits 15:0 of the operands are used and the result is zero-extended into bits 23:16. The 16-bit opcodes are ADD = 0 and SUB = 2 with `inWide` = 0, ADC = 1 and SBC = 3. The flags are set as follows:
  - N is result bit 15.
  - Z is set for a zero result.
  - V is signed overflow.
  - C is the carry out for add. For subtract, C is the borrow: set when the unsigned minuend is less than the subtrahend plus borrow-in.
  - ADC adds the incoming C, and SBC subtracts the incoming C.
- R4: With `inWide` = 1, ADD, SUB and CMP (4) use all 24 bits, and N, V and C are taken at bit 23. For every other opcode, `inWide` has no effect.
- R5: CMP (4) sets the flags exactly as SUB does, and CMC (5) sets them exactly as SBC does. Both keep `outWrite` at 0.
- R6: AND = 6, OR = 7 and XOR = 8 combine bits 15:0 of the two operands; NOT = 9 inverts bits 15:0 of A. For all four:
  - the result is zero-extended;
  - N and Z come from the 16-bit result;
  - V is cleared;
  - C is kept.
- R7: SRL = 10, SRA = 11 and SLL = 12 shift bits 15:0 of A by the unsigned count in B bits 7:0, with the flags set as in R6. A count of 16 or more gives 0; for SRA it gives bit 15 of A copied into all 16 bits.
- R8: SWAP (13) exchanges bits 15:8 and 7:0 of A, zero-fills bits 23:16 and sets the flags as in R6.
- R9: The conversions write their result and leave all flags unchanged:

  | Opcode | Name | Result |
  |---|---|---|
  | 14 | SX8 | sign-extends A bits 7:0 to 24 bits |
  | 15 | SX16 | sign-extends A bits 15:0 to 24 bits |
  | 16 | TRUNC | passes A unchanged (the low 24 bits of a 32-bit value) |
  | 17 | HI24 | the upper word of the 32-bit extension of A: 24 copies of A bit 23 |
  | 18 | HI16 | the upper word of the extension of A bits 15:0: 24 copies of A bit 15 |

- R10: The carry qualifier `inPred` applies to opcodes 0 to 9. Its values are 0 = always, 1 = only when incoming C = 1, 2 = only when incoming C = 0, and 3 = always. When the qualifier fails, `outWrite` is 0 and `outFlags` equals `inFlags`. Opcodes 10 to 18 execute whatever `inPred` holds.
- R11: `outTaken` evaluates `inCond` on `inFlags`, with `^` meaning exclusive OR:

  | Code | Condition | Taken when |
  |---|---|---|
  | 0 | always | 1 |
  | 1 | equal | Z |
  | 2 | not equal | !Z |
  | 3 | signed greater | !Z & !(N^V) |
  | 4 | signed greater or equal | !(N^V) |
  | 5 | signed less | N^V |
  | 6 | signed less or equal | Z \| (N^V) |
  | 7 | higher | !Z & !C |
  | 8 | higher or same | !C |
  | 9 | lower | C |
  | 10 | lower or same | Z \| C |
  | 11 to 15 | never | 0 |

- R12: Opcodes 19 to 31 are no-ops: `outWrite` is 0, `outFlags` equals `inFlags`, and `outTaken` still follows R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Issue strobe |
| inOp | input | 5 | Operation code |
| inWide | input | 1 | Selects the 24-bit form of ADD, SUB and CMP |
| inPred | input | 2 | Carry qualifier |
| inCond | input | 4 | Branch condition select |
| inFlags | input | 4 | Current flags: N, Z, V, C in bits 0 to 3 |
| inA | input | 24 | First operand |
| inB | input | 24 | Second operand; bits 7:0 hold the shift count |
| outValid | output | 1 | Result of the previous issue is present |
| outResult | output | 24 | Result value, meaningful when outWrite is 1 |
| outWrite | output | 1 | Register write strobe |
| outFlags | output | 4 | Next flags |
| outTaken | output | 1 | Branch condition verdict |

## Verification
The bench covers three groups of corner cases.

- **Carry and overflow boundaries at both widths.** It drives 0xFFFF + 1 and 0x00FFFF + 1 in both forms. A design that takes its carry from the wrong bit would report a carry at 24 bits, or miss it at 16. It also tries wide ADC, which must stay at 16 bits.
- **Borrow polarity and the skip rule.** It exercises borrow-in for SBC and CMC. A design with an inverted borrow would flip every unsigned branch verdict. Failed carry qualifiers must leave the write strobe low and the flags untouched, while a shift under a failing qualifier must still run.
- **Shift counts and conditions.** It drives shift counts of 15, 16 and far beyond. A design that wraps the count instead of saturating would return a shifted value where 0 or the sign fill is due. It then sweeps all sixteen condition codes over several flag patterns, next to a long mixed random stream.

// File: rtl/dwalu_pkg.sv
package dwalu_pkg;

  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADC   = 5'd1,
    OP_SUB   = 5'd2,
    OP_SBC   = 5'd3,
    OP_CMP   = 5'd4,
    OP_CMC   = 5'd5,
    OP_AND   = 5'd6,
    OP_OR    = 5'd7,
    OP_XOR   = 5'd8,
    OP_NOT   = 5'd9,
    OP_SRL   = 5'd10,
    OP_SRA   = 5'd11,
    OP_SLL   = 5'd12,
    OP_SWAP  = 5'd13,
    OP_SX8   = 5'd14,
    OP_SX16  = 5'd15,
    OP_TRUNC = 5'd16,
    OP_HI24  = 5'd17,
    OP_HI16  = 5'd18
  } aluOp_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_ARITH,
    SRC_LOGIC,
    SRC_SHIFT,
    SRC_SWAP,
    SRC_CONV
  } resSrc_e;

  // Strobes from control to datapath
  typedef struct packed {
    resSrc_e    src;
    logic       sub;       // subtract instead of add
    logic       useCarry;  // chain the incoming carry or borrow
    logic       wide;      // full register width
    logic [2:0] fn;        // sub-function inside the logic, shift or conv group
    logic       exec;      // carry qualifier passed
    logic       writeRes;
    logic       updNZ;
    logic       updV;
    logic       updC;
  } aluStrobe_t;

  localparam int FLAG_N = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_V = 2;
  localparam int FLAG_C = 3;

  localparam logic [1:0] PRED_CSET = 2'd1;
  localparam logic [1:0] PRED_CCLR = 2'd2;

endpackage

// File: rtl/dwalu_ctrl.sv
module dwalu_ctrl
  import dwalu_pkg::*;
(
  input  logic [4:0] op,
  input  logic       wideReq,
  input  logic [1:0] pred,
  input  logic       carryIn,
  output aluStrobe_t stb
);

  logic qualifiable;
  logic predPass;

  always_comb begin
    qualifiable = (op <= 5'(OP_NOT));
    case (pred)
      PRED_CSET: predPass = carryIn;
      PRED_CCLR: predPass = !carryIn;
      default:   predPass = 1'b1;
    endcase
  end

  always_comb begin
    stb          = '0;
    stb.src      = SRC_NONE;
    stb.exec     = qualifiable ? predPass : 1'b1;
    case (aluOp_e'(op))
      OP_ADD, OP_SUB, OP_CMP: begin
        stb.src      = SRC_ARITH;
        stb.sub      = (aluOp_e'(op) != OP_ADD);
        stb.wide     = wideReq;
        stb.writeRes = (aluOp_e'(op) != OP_CMP);
        stb.updNZ    = 1'b1;
        stb.updV     = 1'b1;
        stb.updC     = 1'b1;
      end
      OP_ADC, OP_SBC, OP_CMC: begin
        stb.src      = SRC_ARITH;
        stb.sub      = (aluOp_e'(op) != OP_ADC);
        stb.useCarry = 1'b1;
        stb.writeRes = (aluOp_e'(op) != OP_CMC);
        stb.updNZ    = 1'b1;
        stb.updV     = 1'b1;
        stb.updC     = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        stb.src      = SRC_LOGIC;
        stb.fn       = 3'(op - 5'(OP_AND));
        stb.writeRes = 1'b1;
        stb.updNZ    = 1'b1;
        stb.updV     = 1'b1;
      end
      OP_SRL, OP_SRA, OP_SLL: begin
        stb.src      = SRC_SHIFT;
        stb.fn       = 3'(op - 5'(OP_SRL));
        stb.writeRes = 1'b1;
        stb.updNZ    = 1'b1;
        stb.updV     = 1'b1;
      end
      OP_SWAP: begin
        stb.src      = SRC_SWAP;
        stb.writeRes = 1'b1;
        stb.updNZ    = 1'b1;
        stb.updV     = 1'b1;
      end
      OP_SX8, OP_SX16, OP_TRUNC, OP_HI24, OP_HI16: begin
        stb.src      = SRC_CONV;
        stb.fn       = 3'(op - 5'(OP_SX8));
        stb.writeRes = 1'b1;
      end
      default: stb.src = SRC_NONE;
    endcase
  end

endmodule

// File: rtl/dwalu_dp.sv
module dwalu_dp
  import dwalu_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input  aluStrobe_t        stb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [3:0]        flagsNext
);

  localparam int HALF_W = NARROW_W / 2;
  localparam int CNT_W  = 8;
  localparam int EXT_W  = DATA_W - NARROW_W;

  logic [DATA_W-1:0]   aW, bW, arithSel, arithRes, convRes;
  logic [DATA_W:0]     addRaw, subRaw;
  logic [NARROW_W-1:0] a16, b16, logicRes, shiftRes, swapRes;
  logic [CNT_W-1:0]    cnt;
  logic                cin, carryOut, ovf, signA, signB, signR, resN, resZ;

  // Operand width selection
  always_comb begin
    a16 = opA[NARROW_W-1:0];
    b16 = opB[NARROW_W-1:0];
    aW  = stb.wide ? opA : {{EXT_W{1'b0}}, a16};
    bW  = stb.wide ? opB : {{EXT_W{1'b0}}, b16};
    cin = stb.useCarry & flagsIn[FLAG_C];
  end

  // Adder and subtractor with carry or borrow
  always_comb begin
    addRaw   = {1'b0, aW} + {1'b0, bW} + {{DATA_W{1'b0}}, cin};
    subRaw   = {1'b0, aW} - {1'b0, bW} - {{DATA_W{1'b0}}, cin};
    arithSel = stb.sub ? subRaw[DATA_W-1:0] : addRaw[DATA_W-1:0];
    arithRes = stb.wide ? arithSel : {{EXT_W{1'b0}}, arithSel[NARROW_W-1:0]};
    if (stb.sub) carryOut = subRaw[DATA_W];
    else         carryOut = stb.wide ? addRaw[DATA_W] : addRaw[NARROW_W];
    signA = stb.wide ? aW[DATA_W-1] : aW[NARROW_W-1];
    signB = stb.wide ? bW[DATA_W-1] : bW[NARROW_W-1];
    signR = stb.wide ? arithRes[DATA_W-1] : arithRes[NARROW_W-1];
    ovf   = stb.sub ? ((signA != signB) && (signR != signA))
                    : ((signA == signB) && (signR != signA));
  end

  // Logical, shift, swap and conversion units
  always_comb begin
    case (stb.fn)
      3'd0:    logicRes = a16 & b16;
      3'd1:    logicRes = a16 | b16;
      3'd2:    logicRes = a16 ^ b16;
      default: logicRes = ~a16;
    endcase
    cnt = opB[CNT_W-1:0];
    case (stb.fn)
      3'd0:    shiftRes = a16 >> cnt;
      3'd1:    shiftRes = $signed(a16) >>> cnt;
      default: shiftRes = a16 << cnt;
    endcase
    swapRes = {a16[HALF_W-1:0], a16[NARROW_W-1:HALF_W]};
    case (stb.fn)
      3'd0:    convRes = {{(DATA_W-8){opA[7]}}, opA[7:0]};
      3'd1:    convRes = {{EXT_W{opA[NARROW_W-1]}}, a16};
      3'd2:    convRes = opA;
      3'd3:    convRes = {DATA_W{opA[DATA_W-1]}};
      default: convRes = {DATA_W{opA[NARROW_W-1]}};
    endcase
  end

  // Result selection and flag update
  always_comb begin
    case (stb.src)
      SRC_ARITH: result = arithRes;
      SRC_LOGIC: result = {{EXT_W{1'b0}}, logicRes};
      SRC_SHIFT: result = {{EXT_W{1'b0}}, shiftRes};
      SRC_SWAP:  result = {{EXT_W{1'b0}}, swapRes};
      SRC_CONV:  result = convRes;
      default:   result = '0;
    endcase
    resN = (stb.src == SRC_ARITH && stb.wide) ? result[DATA_W-1] : result[NARROW_W-1];
    resZ = (result == '0);
    flagsNext = flagsIn;
    if (stb.exec) begin
      if (stb.updNZ) begin
        flagsNext[FLAG_N] = resN;
        flagsNext[FLAG_Z] = resZ;
      end
      if (stb.updV) flagsNext[FLAG_V] = (stb.src == SRC_ARITH) ? ovf : 1'b0;
      if (stb.updC) flagsNext[FLAG_C] = carryOut;
    end
    writeEn = stb.exec & stb.writeRes;
  end

endmodule

// File: rtl/dwalu_cond.sv
module dwalu_cond
  import dwalu_pkg::*;
(
  input  logic [3:0] cond,
  input  logic [3:0] flags,
  output logic       taken
);

  logic n, z, v, c, lt;

  always_comb begin
    n  = flags[FLAG_N];
    z  = flags[FLAG_Z];
    v  = flags[FLAG_V];
    c  = flags[FLAG_C];
    lt = n ^ v;
    case (cond)
      4'd0:    taken = 1'b1;
      4'd1:    taken = z;
      4'd2:    taken = !z;
      4'd3:    taken = !z && !lt;
      4'd4:    taken = !lt;
      4'd5:    taken = lt;
      4'd6:    taken = z || lt;
      4'd7:    taken = !z && !c;
      4'd8:    taken = !c;
      4'd9:    taken = c;
      4'd10:   taken = z || c;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/dual_width_alu.sv
module dual_width_alu
  import dwalu_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [4:0]        inOp,
  input  logic              inWide,
  input  logic [1:0]        inPred,
  input  logic [3:0]        inCond,
  input  logic [3:0]        inFlags,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult,
  output logic              outWrite,
  output logic [3:0]        outFlags,
  output logic              outTaken
);

  aluStrobe_t        stb;
  logic [DATA_W-1:0] dpResult;
  logic              dpWrite;
  logic [3:0]        dpFlags;
  logic              condTaken;

  dwalu_ctrl i_ctrl (
    .op      (inOp),
    .wideReq (inWide),
    .pred    (inPred),
    .carryIn (inFlags[FLAG_C]),
    .stb     (stb)
  );

  dwalu_dp #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_dp (
    .stb       (stb),
    .opA       (inA),
    .opB       (inB),
    .flagsIn   (inFlags),
    .result    (dpResult),
    .writeEn   (dpWrite),
    .flagsNext (dpFlags)
  );

  dwalu_cond i_cond (
    .cond  (inCond),
    .flags (inFlags),
    .taken (condTaken)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outWrite  <= 1'b0;
      outResult <= '0;
      outFlags  <= '0;
      outTaken  <= 1'b0;
    end else begin
      outValid <= inValid;
      outWrite <= inValid & dpWrite;
      if (inValid) begin
        outResult <= dpResult;
        outFlags  <= dpFlags;
        outTaken  <= condTaken;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && !outWrite));

  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inOp == OP_CMP || inOp == OP_CMC)) |=> !outWrite);

  assert_skip_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp <= 5'(OP_NOT) && inPred == PRED_CSET && !inFlags[FLAG_C])
      |=> (!outWrite && outFlags == $past(inFlags)));

  assert_logic_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp >= 5'(OP_AND) && inOp <= 5'(OP_NOT))
      |=> (outFlags[FLAG_C] == $past(inFlags[FLAG_C])));

  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inOp <= 5'(OP_SWAP) &&
     !(inWide && (inOp == OP_ADD || inOp == OP_SUB || inOp == OP_CMP)))
      |=> (outResult[DATA_W-1:NARROW_W] == '0));

  assert_equal_cond_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inCond == 4'd1) |=> (outTaken == $past(inFlags[FLAG_Z])));

endmodule

// File: tb/test_dual_width_alu.sv
module test_dual_width_alu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [4:0]  inOp = '0;
  logic        inWide = 1'b0;
  logic [1:0]  inPred = '0;
  logic [3:0]  inCond = '0;
  logic [3:0]  inFlags = '0;
  logic [23:0] inA = '0;
  logic [23:0] inB = '0;
  logic        outValid;
  logic [23:0] outResult;
  logic        outWrite;
  logic [3:0]  outFlags;
  logic        outTaken;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [23:0] r;
    logic        we;
    logic [3:0]  f;
    logic        t;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  dual_width_alu i_dual_width_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inWide(inWide),
    .inPred(inPred), .inCond(inCond), .inFlags(inFlags), .inA(inA), .inB(inB),
    .outValid(outValid), .outResult(outResult), .outWrite(outWrite),
    .outFlags(outFlags), .outTaken(outTaken)
  );

  // Flags as {C,V,Z,N}
  function automatic logic condModel(input logic [3:0] cs, input logic [3:0] f);
    logic n, z, v, c;
    n = f[0]; z = f[1]; v = f[2]; c = f[3];
    case (cs)
      4'd0:  return 1'b1;
      4'd1:  return z;
      4'd2:  return !z;
      4'd3:  return !z && (n == v);
      4'd4:  return n == v;
      4'd5:  return n != v;
      4'd6:  return z || (n != v);
      4'd7:  return !z && !c;
      4'd8:  return !c;
      4'd9:  return c;
      4'd10: return z || c;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void aluModel(input logic [4:0] op, input logic [23:0] a, input logic [23:0] b,
                                   input logic w, input logic [1:0] pred, input logic [3:0] f,
                                   output logic [23:0] r, output logic we, output logic [3:0] nf);
    logic pass, isW, isSub, cin, c, v, n;
    logic [24:0] t25;
    logic [16:0] t17;
    logic [15:0] x, a16;
    int cnt;
    r = 24'h0; we = 1'b0; nf = f;
    a16 = a[15:0];
    pass = (pred == 2'd1) ? f[3] : (pred == 2'd2) ? !f[3] : 1'b1;
    if (op <= 5'd9 && !pass) return;
    if (op <= 5'd5) begin
      isW   = w && (op == 5'd0 || op == 5'd2 || op == 5'd4);
      isSub = (op >= 5'd2);
      cin   = (op == 5'd1 || op == 5'd3 || op == 5'd5) ? f[3] : 1'b0;
      if (isW) begin
        if (isSub) begin
          r = a - b - {23'h0, cin};
          c = ({1'b0, a} < ({1'b0, b} + {24'h0, cin}));
          v = (a[23] != b[23]) && (r[23] != a[23]);
        end else begin
          t25 = {1'b0, a} + {1'b0, b} + {24'h0, cin};
          r = t25[23:0]; c = t25[24];
          v = (a[23] == b[23]) && (r[23] != a[23]);
        end
        n = r[23];
      end else begin
        if (isSub) begin
          x = a16 - b[15:0] - {15'h0, cin};
          c = ({1'b0, a16} < ({1'b0, b[15:0]} + {16'h0, cin}));
          v = (a16[15] != b[15]) && (x[15] != a16[15]);
        end else begin
          t17 = {1'b0, a16} + {1'b0, b[15:0]} + {16'h0, cin};
          x = t17[15:0]; c = t17[16];
          v = (a16[15] == b[15]) && (x[15] != a16[15]);
        end
        r = {8'h0, x};
        n = x[15];
      end
      nf = {c, v, (r == 24'h0), n};
      we = (op != 5'd4 && op != 5'd5);
    end else if (op <= 5'd13) begin
      cnt = int'(b[7:0]);
      case (op)
        5'd6:  x = a16 & b[15:0];
        5'd7:  x = a16 | b[15:0];
        5'd8:  x = a16 ^ b[15:0];
        5'd9:  x = ~a16;
        5'd10: x = (cnt >= 16) ? 16'h0 : (a16 >> cnt);
        5'd11: x = (cnt >= 16) ? {16{a16[15]}} : 16'($signed(a16) >>> cnt);
        5'd12: x = (cnt >= 16) ? 16'h0 : (a16 << cnt);
        default: x = {a16[7:0], a16[15:8]};
      endcase
      r = {8'h0, x};
      nf = {f[3], 1'b0, (x == 16'h0), x[15]};
      we = 1'b1;
    end else if (op <= 5'd18) begin
      case (op)
        5'd14: r = {{16{a[7]}}, a[7:0]};
        5'd15: r = {{8{a[15]}}, a[15:0]};
        5'd16: r = a;
        5'd17: r = {24{a[23]}};
        default: r = {24{a[15]}};
      endcase
      we = 1'b1;
    end
  endfunction

  task automatic send(input logic [4:0] op, input logic [23:0] a, input logic [23:0] b,
                      input logic w, input logic [1:0] pred, input logic [3:0] cs,
                      input logic [3:0] f, input string tag);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1; inOp = op; inA = a; inB = b; inWide = w;
    inPred = pred; inCond = cs; inFlags = f;
    aluModel(op, a, b, w, pred, f, e.r, e.we, e.f);
    e.t = condModel(cs, f);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: compares each result with the scoreboard
  initial begin
    exp_t e;
    string tg;
    forever begin
      @(posedge clk);
      #2;
      if (rstN && outValid) begin
        total++;
        if (expQ.size() == 0) begin
          bad++;
          $display("FAIL R2 unexpected outValid: actual=1 expected=0");
        end else begin
          e = expQ.pop_front();
          tg = tagQ.pop_front();
          if (outTaken !== e.t) begin
            bad++;
            $display("FAIL R11 (%s) taken: actual=%0b expected=%0b", tg, outTaken, e.t);
          end else if (outWrite !== e.we || outFlags !== e.f || (e.we && outResult !== e.r)) begin
            bad++;
            $display("FAIL %s: actual we=%0b flags=%h res=%h expected we=%0b flags=%h res=%h",
                     tg, outWrite, outFlags, outResult, e.we, e.f, e.r);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finishRun();
  end

  function automatic string tagFor(input logic [4:0] op, input logic w, input logic [1:0] pred,
                                   input logic [3:0] f);
    logic pass;
    pass = (pred == 2'd1) ? f[3] : (pred == 2'd2) ? !f[3] : 1'b1;
    if (op <= 5'd9 && !pass) return "R10";
    if (op <= 5'd3) return (w && (op == 5'd0 || op == 5'd2)) ? "R4" : "R3";
    if (op <= 5'd5) return (w && op == 5'd4) ? "R4" : "R5";
    if (op <= 5'd9) return "R6";
    if (op <= 5'd12) return "R7";
    if (op == 5'd13) return "R8";
    if (op <= 5'd18) return "R9";
    return "R12";
  endfunction

  initial begin
    // R1: reset state
    #35;
    total++;
    if (outValid !== 1'b0 || outWrite !== 1'b0 || outTaken !== 1'b0 ||
        outResult !== 24'h0 || outFlags !== 4'h0) begin
      bad++;
      $display("FAIL R1 reset: actual v=%0b we=%0b t=%0b res=%h f=%h expected all zero",
               outValid, outWrite, outTaken, outResult, outFlags);
    end
    @(negedge clk);
    rstN = 1'b1;
    idle(2);

    // R3: narrow arithmetic
    send(5'd0, 24'h12FFFF, 24'h000001, 1'b0, 2'd0, 4'd1, 4'h0, "R3 add carry");
    send(5'd0, 24'h007FFF, 24'h000001, 1'b0, 2'd0, 4'd0, 4'h0, "R3 add ovf");
    send(5'd1, 24'h000001, 24'h000001, 1'b0, 2'd0, 4'd9, 4'h8, "R3 adc");
    send(5'd2, 24'h000000, 24'h000001, 1'b0, 2'd0, 4'd7, 4'h0, "R3 sub borrow");
    send(5'd3, 24'h000005, 24'h000005, 1'b0, 2'd0, 4'd8, 4'h8, "R3 sbc borrow");
    send(5'd2, 24'h008000, 24'h000001, 1'b0, 2'd0, 4'd5, 4'h0, "R3 sub ovf");
    // R4: wide forms and wide ignored
    send(5'd0, 24'hFFFFFF, 24'h000001, 1'b1, 2'd0, 4'd0, 4'h0, "R4 wide add carry");
    send(5'd0, 24'h00FFFF, 24'h000001, 1'b1, 2'd0, 4'd0, 4'h0, "R4 wide add no carry");
    send(5'd1, 24'h00FFFF, 24'h000000, 1'b1, 2'd0, 4'd0, 4'h8, "R4 wide ignored adc");
    send(5'd2, 24'h800000, 24'h000001, 1'b1, 2'd0, 4'd0, 4'h0, "R4 wide sub ovf");
    send(5'd4, 24'h100000, 24'h200000, 1'b1, 2'd0, 4'd0, 4'h0, "R4 wide cmp");
    // R5: compare
    send(5'd4, 24'h001234, 24'h001234, 1'b0, 2'd0, 4'd0, 4'h0, "R5 cmp equal");
    send(5'd5, 24'h000003, 24'h000003, 1'b0, 2'd0, 4'd0, 4'h8, "R5 cmc borrow");
    // R6: logic with C and V set beforehand
    send(5'd6, 24'hFF00F0, 24'h0000FF, 1'b0, 2'd0, 4'd0, 4'hC, "R6 and");
    send(5'd7, 24'h000000, 24'h000000, 1'b0, 2'd0, 4'd0, 4'h4, "R6 or zero");
    send(5'd8, 24'h00AAAA, 24'h005555, 1'b0, 2'd0, 4'd0, 4'hC, "R6 xor");
    send(5'd9, 24'hAB0000, 24'h000000, 1'b1, 2'd0, 4'd0, 4'h8, "R6 not");
    // R7: shift counts
    send(5'd10, 24'h008000, 24'h00000F, 1'b0, 2'd0, 4'd0, 4'h8, "R7 srl 15");
    send(5'd10, 24'h00FFFF, 24'h000000, 1'b0, 2'd0, 4'd0, 4'h0, "R7 srl 0");
    send(5'd11, 24'h008000, 24'h000010, 1'b0, 2'd0, 4'd0, 4'h0, "R7 sra 16");
    send(5'd11, 24'h008000, 24'h0000C8, 1'b0, 2'd0, 4'd0, 4'h0, "R7 sra 200");
    send(5'd11, 24'h004000, 24'h000003, 1'b0, 2'd0, 4'd0, 4'h0, "R7 sra 3");
    send(5'd12, 24'h000001, 24'h000010, 1'b0, 2'd0, 4'd0, 4'h8, "R7 sll 16");
    send(5'd12, 24'h000001, 24'h00000F, 1'b0, 2'd0, 4'd0, 4'h0, "R7 sll 15");
    // R8: swap
    send(5'd13, 24'hAB1234, 24'h000000, 1'b0, 2'd0, 4'd0, 4'h8, "R8 swap");
    // R9: conversions
    send(5'd14, 24'h000080, 24'h0, 1'b0, 2'd0, 4'd0, 4'h5, "R9 sx8");
    send(5'd15, 24'h008001, 24'h0, 1'b0, 2'd0, 4'd0, 4'hA, "R9 sx16");
    send(5'd16, 24'hABCDEF, 24'h0, 1'b0, 2'd0, 4'd0, 4'h0, "R9 trunc");
    send(5'd17, 24'h800000, 24'h0, 1'b0, 2'd0, 4'd0, 4'h0, "R9 hi24");
    send(5'd18, 24'h7F8000, 24'h0, 1'b0, 2'd0, 4'd0, 4'h0, "R9 hi16");
    // R10: carry qualifier
    send(5'd0, 24'h000001, 24'h000001, 1'b0, 2'd1, 4'd0, 4'h2, "R10 /c fails");
    send(5'd0, 24'h000001, 24'h000001, 1'b0, 2'd1, 4'd0, 4'h8, "R10 /c passes");
    send(5'd6, 24'h00FFFF, 24'h00FFFF, 1'b0, 2'd2, 4'd0, 4'h9, "R10 /nc fails");
    send(5'd4, 24'h000000, 24'h000001, 1'b0, 2'd2, 4'd0, 4'h0, "R10 /nc passes");
    send(5'd10, 24'h000010, 24'h000001, 1'b0, 2'd1, 4'd0, 4'h0, "R10 shift ignores");
    send(5'd2, 24'h000009, 24'h000001, 1'b0, 2'd3, 4'd0, 4'h0, "R10 pred3 always");
    // R11 and R12: every condition code over several flag patterns, no-op opcode
    for (int fp = 0; fp < 16; fp += 5)
      for (int cs = 0; cs < 16; cs++)
        send(5'd19 + 5'(cs % 13), 24'h123456, 24'h654321, 1'b0, 2'd0, 4'(cs), 4'(fp),
             "R11 R12 cond sweep");
    idle(3);
    // R2: idle gives no valid output
    total++;
    if (outValid !== 1'b0 || outWrite !== 1'b0) begin
      bad++;
      $display("FAIL R2 idle: actual v=%0b we=%0b expected 0 0", outValid, outWrite);
    end
    // Mixed random stream
    for (int i = 0; i < 300; i++) begin
      logic [4:0] op;
      logic w;
      logic [1:0] pr;
      logic [3:0] fl;
      op = 5'($urandom_range(0, 20));
      w  = 1'($urandom);
      pr = 2'($urandom);
      fl = 4'($urandom);
      send(op, 24'($urandom), (op >= 5'd10 && op <= 5'd12) ? 24'($urandom_range(0, 20)) : 24'($urandom),
           w, pr, 4'($urandom), fl, tagFor(op, w, pr, fl));
    end
    idle(4);
    if (expQ.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R2 missing results: actual=%0d pending expected=0", expQ.size());
    end
    finishRun();
  end

endmodule